// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block watches the command strobes an SDRAM controller drives toward its memory and tracks, for each bank, whether that bank is closed, open, waiting on an automatic close, or recovering from a precharge. Every rising clock edge it decodes chip-select, row strobe, column strobe and write enable together with the auto/all-bank address bit and the bank-select bits. From that it knows when a precharge may legally follow a read or write burst and when a closed bank may be activated again.

For every bank it drives two permission outputs: one that says an activate is legal in the current cycle and one that says an explicit precharge is legal. A controller can use them to gate its own command choice. A single violation flag reports any command on the bus that breaks an ordering or timing rule. A command that violates a rule never changes the tracked state. Burst length, CAS latency, the precharge recovery time and the write-data-to-precharge delay are parameters. The defaults are burst 4, latency 3, recovery 2 clocks and write-to-precharge delay 2 clocks.

Top module: `sdram_bank_guard`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} at each rising edge: 0011 activate, 0101 read, 0100 write, 0010 precharge. Any other pattern, and every cycle with cs_n high, changes no bank state and raises no violation.
- R2: After reset every bank is closed: act_ok is all ones, pre_ok is all zeros and viol is 0.
- R3: An activate to a bank that is closed, or whose recovery has finished, opens it. In the next cycle act_ok for that bank is 0 and pre_ok is 1. An activate to a bank that is open, pending auto-close or still recovering is a violation.
- R4: After a read to an open bank issued in cycle t, pre_ok for that bank is 0 from cycle t+1 and returns to 1 in cycle t+BL. This point lies CL-1 clocks before the last read data beat.
- R5: After a write to an open bank issued in cycle t, pre_ok for that bank is 0 until it returns to 1 in cycle t+BL+TDPL-1.
- R6: A precharge with addr_ap low accepted in cycle t closes only the bank named by bank_sel. That bank's act_ok is 0 until it returns to 1 in cycle t+TRP. Other banks are unaffected.
- R7: A precharge with addr_ap high applies to every bank and ignores bank_sel. Each open bank whose precharge is legal starts recovery.
- R8: A precharge to an open bank whose pre_ok is 0 is a violation, and the bank stays open.
- R9: A read or write to a bank that is not open is a violation and changes nothing.
- R10: A read or write with addr_ap high to an open bank starts an automatic close. The internal precharge begins in the first cycle an explicit precharge would have been legal (R4/R5). pre_ok stays 0 throughout, and act_ok returns to 1 TRP cycles after that start.
- R11: A read or write to any other bank while a bank waits for its automatic close starts that bank's internal precharge at that cycle. Its act_ok returns to 1 TRP cycles later.
- R12: viol is 1 in exactly the cycle after a violating command and 0 otherwise.
- R13: A precharge aimed at a bank that is closed or already recovering has no effect and is not a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr_ap | input | 1 | Auto-close on read/write; all-bank on precharge |
| bank_sel | input | $clog2(NB) | Bank addressed by the command |
| act_ok | output | NB | Per bank: activate legal this cycle |
| pre_ok | output | NB | Per bank: explicit precharge legal this cycle |
| viol | output | 1 | A command in the previous cycle broke a rule |

## Verification
Every result is registered once. The permission outputs and viol reflect a command sampled at edge t during cycle t+1. Timed windows count from there: pre_ok rises in cycle t+BL after a read and in cycle t+BL+TDPL-1 after a write, and act_ok rises in cycle t+TRP after a precharge. The bench drives each command on a falling edge and compares all outputs on the following falling edge. It checks them against a model kept in absolute cycle numbers, and its directed checks step with NOPs to the exact cycle before and the exact cycle of each window's end.

// File: rtl/sbg_pkg.sv
// Shared types for the SDRAM bank guard.
// Assumes: one command per clock, bank count is a power of two.
package sbg_pkg;

    // Decoded command class seen on the bus this cycle.
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4
    } sbg_cmd_e;

    // Per-bank tracking state.
    typedef enum logic [1:0] {
        BK_IDLE      = 2'd0,  // closed, may be activated
        BK_ACTIVE    = 2'd1,  // open, counter holds off precharge
        BK_CLOSING   = 2'd2,  // precharging, counter holds off activate
        BK_AUTOCLOSE = 2'd3   // open, internal precharge pending
    } sbg_bank_e;

    // Larger of two integers, for parameter arithmetic.
    function automatic int sbg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sbg_cmd_decode.sv
// Command decoder: turns the four strobes into a command class and a
// per-bank target vector. Assumes addr_ap only widens precharge targets.
module sbg_cmd_decode
    import sbg_pkg::*;
#(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          ap_i,
    input  logic [BW-1:0] bank_i,
    output sbg_cmd_e      cmd_o,
    output logic [NB-1:0] sel_o
);

    // Strobe pattern to command class.
    always_comb begin
        cmd_o = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end

    // One target line per bank; all lines on an all-bank precharge.
    for (genvar b = 0; b < NB; b++) begin : g_sel
        always_comb begin
            sel_o[b] = (cmd_o != CMD_NONE) &&
                       ((bank_i == BW'(b)) || (cmd_o == CMD_PRE && ap_i));
        end
    end

endmodule

// File: rtl/sbg_bank_track.sv
// One bank's state and hold-off counter. The counter is a saturating
// down-counter: while open it delays precharge, while closing it delays
// activate, while auto-closing it delays the internal precharge.
// Assumes: a violating command leaves state and counter as they would
// be after a NOP.
module sbg_bank_track
    import sbg_pkg::*;
#(
    parameter int BL   = 4,
    parameter int CL   = 3,
    parameter int TRP  = 2,
    parameter int TDPL = 2,
    // Read: last beat at t+CL+BL-1, precharge allowed CL-1 earlier.
    localparam int RD_HOLD = (CL + BL - 1) - (CL - 1) - 1,
    localparam int WR_HOLD = BL + TDPL - 2,
    localparam int MAXH    = sbg_max(sbg_max(RD_HOLD, WR_HOLD), TRP - 1),
    localparam int CW      = $clog2(MAXH + 2)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sbg_cmd_e cmd_i,
    input  logic     hit_i,
    input  logic     ap_i,
    input  logic     other_rw_i,
    output logic     act_ok_o,
    output logic     pre_ok_o,
    output logic     viol_o
);

    localparam logic [CW-1:0] RD_LD  = CW'(RD_HOLD);
    localparam logic [CW-1:0] WR_LD  = CW'(WR_HOLD);
    localparam logic [CW-1:0] TRP_LD = CW'(TRP - 1);

    sbg_bank_e     state, state_n;
    logic [CW-1:0] cnt, cnt_n, cnt_dec, load;

    // Permissions follow directly from state and counter.
    always_comb begin
        act_ok_o = (state == BK_IDLE) || (state == BK_CLOSING && cnt == '0);
        pre_ok_o = (state == BK_ACTIVE) && (cnt == '0);
    end

    // Next state, next counter and violation for this bank.
    always_comb begin
        cnt_dec = (cnt == '0) ? '0 : cnt - 1'b1;
        state_n = state;
        cnt_n   = cnt_dec;
        viol_o  = 1'b0;
        load    = (cmd_i == CMD_RD) ? RD_LD : WR_LD;

        case (state)
            BK_CLOSING: begin
                if (cnt == '0) state_n = BK_IDLE;
            end
            BK_AUTOCLOSE: begin
                if (cnt == '0 || other_rw_i) begin
                    state_n = BK_CLOSING;
                    cnt_n   = TRP_LD;
                end
            end
            default: ;
        endcase

        if (hit_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    if (act_ok_o) begin
                        state_n = BK_ACTIVE;
                        cnt_n   = '0;
                    end else begin
                        viol_o = 1'b1;
                    end
                end
                CMD_RD, CMD_WR: begin
                    if (state == BK_ACTIVE) begin
                        cnt_n = (cnt_dec > load) ? cnt_dec : load;
                        if (ap_i) state_n = BK_AUTOCLOSE;
                    end else begin
                        viol_o = 1'b1;
                    end
                end
                CMD_PRE: begin
                    if (state == BK_ACTIVE) begin
                        if (cnt == '0) begin
                            state_n = BK_CLOSING;
                            cnt_n   = TRP_LD;
                        end else begin
                            viol_o = 1'b1;
                        end
                    end else if (state == BK_AUTOCLOSE) begin
                        viol_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // A bank only opens in a cycle after activate was permitted.
    assert_open_needs_allow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_ACTIVE && $past(state) != BK_ACTIVE) |-> $past(act_ok_o));

    // An open bank only starts closing after precharge was permitted.
    assert_close_needs_allow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_CLOSING && $past(state) == BK_ACTIVE) |-> $past(pre_ok_o));

    // The hold-off counter never exceeds the largest load value.
    assert_hold_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXH));

    // Auto-close turns into precharge only on expiry or interruption.
    assert_auto_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_CLOSING && $past(state) == BK_AUTOCLOSE)
        |-> ($past(cnt) == '0 || $past(other_rw_i)));

endmodule

// File: rtl/sdram_bank_guard.sv
// Top: decodes the SDRAM command bus, runs one tracker per bank and
// registers the merged violation flag. Assumes one command per clock.
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BL   = 4,
    parameter int CL   = 3,
    parameter int TRP  = 2,
    parameter int TDPL = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  addr_ap,
    input  logic [$clog2(NB)-1:0] bank_sel,
    output logic [NB-1:0]         act_ok,
    output logic [NB-1:0]         pre_ok,
    output logic                  viol
);

    sbg_cmd_e      cmd;
    logic [NB-1:0] sel;
    logic [NB-1:0] bank_viol;
    logic          is_rw;

    sbg_cmd_decode #(.NB(NB)) u_dec (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ap_i   (addr_ap),
        .bank_i (bank_sel),
        .cmd_o  (cmd),
        .sel_o  (sel)
    );

    // Read or write this cycle, used to interrupt pending auto-closes.
    always_comb is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sbg_bank_track #(
            .BL(BL), .CL(CL), .TRP(TRP), .TDPL(TDPL)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_i      (cmd),
            .hit_i      (sel[b]),
            .ap_i       (addr_ap),
            .other_rw_i (is_rw && !sel[b]),
            .act_ok_o   (act_ok[b]),
            .pre_ok_o   (pre_ok[b]),
            .viol_o     (bank_viol[b])
        );
    end

    // Violation flag, one cycle after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= |bank_viol;
    end

    // Idle bus cycles never produce a violation.
    assert_quiet_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd == CMD_NONE) |-> !viol);

    // A bank that opened was addressed by an activate.
    assert_open_by_act_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_ok) & ~act_ok & pre_ok) != '0 |-> $past(cmd == CMD_ACT));

endmodule

// File: tb/sdram_bank_guard_tb_top.sv
`timescale 1ns/1ps
module sdram_bank_guard_tb_top;

    localparam int NB   = 4;
    localparam int BL   = 4;
    localparam int CL   = 3;
    localparam int TRP  = 2;
    localparam int TDPL = 2;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic addr_ap = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic [NB-1:0] act_ok, pre_ok;
    logic viol;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Model: 0 closed, 1 open, 2 recovering, 3 auto-close pending.
    int st[NB];
    int pre_from[NB];
    int act_from[NB];
    int ap_at[NB];
    bit exp_viol;

    always #2.5 clk = ~clk;

    sdram_bank_guard #(.NB(NB), .BL(BL), .CL(CL), .TRP(TRP), .TDPL(TDPL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr_ap(addr_ap), .bank_sel(bank_sel),
        .act_ok(act_ok), .pre_ok(pre_ok), .viol(viol)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic bit m_act(input int b);
        return st[b] == 0 || (st[b] == 2 && cyc >= act_from[b]);
    endfunction

    function automatic bit m_pre(input int b);
        return st[b] == 1 && cyc >= pre_from[b];
    endfunction

    // Advance the model by the command sampled at edge of cycle c.
    task automatic model(input logic [3:0] c, input int bk, input bit a);
        int kind;  // 0 none 1 act 2 rd 3 wr 4 pre
        bit v = 0;
        kind = 0;
        if (c == C_ACT) kind = 1;
        else if (c == C_RD) kind = 2;
        else if (c == C_WR) kind = 3;
        else if (c == C_PRE) kind = 4;
        for (int b = 0; b < NB; b++) begin
            int ost = st[b];
            bit hit = (kind != 0) && (bk == b || (kind == 4 && a));
            if (ost == 3 && (cyc >= ap_at[b] || ((kind == 2 || kind == 3) && bk != b))) begin
                st[b] = 2; act_from[b] = cyc + TRP;
            end
            if (hit) begin
                if (kind == 1) begin
                    if (ost == 0 || (ost == 2 && cyc >= act_from[b])) begin
                        st[b] = 1; pre_from[b] = cyc;
                    end else v = 1;
                end else if (kind == 2 || kind == 3) begin
                    if (ost == 1) begin
                        int h = (kind == 2) ? cyc + BL : cyc + BL + TDPL - 1;
                        if (h > pre_from[b]) pre_from[b] = h;
                        if (a) begin st[b] = 3; ap_at[b] = pre_from[b]; end
                    end else v = 1;
                end else begin
                    if (ost == 1) begin
                        if (cyc >= pre_from[b]) begin st[b] = 2; act_from[b] = cyc + TRP; end
                        else v = 1;
                    end else if (ost == 3) v = 1;
                end
            end
        end
        exp_viol = v;
    endtask

    // Drive one command, let it be sampled, compare all outputs.
    task automatic step(input logic [3:0] c, input int bk, input bit a);
        {cs_n, ras_n, cas_n, we_n} = c;
        bank_sel = 2'(bk);
        addr_ap = a;
        @(posedge clk);
        model(c, bk, a);
        cyc++;
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            chk(act_ok[b], m_act(b), "R6 act_ok model");
            chk(pre_ok[b], m_pre(b), "R4 pre_ok model");
        end
        chk(viol, exp_viol, "R12 viol model");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            st[b] = 0; pre_from[b] = 0; act_from[b] = 0; ap_at[b] = 0;
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(act_ok, 4'hF, "R2 reset act_ok");
        chk(pre_ok, 4'h0, "R2 reset pre_ok");
        chk(viol, 1'b0, "R2 reset viol");

        // R3: open, then re-open is a violation.
        step(C_ACT, 0, 0);
        chk(pre_ok[0], 1'b1, "R3 opened pre_ok");
        chk(act_ok[0], 1'b0, "R3 opened act_ok");
        step(C_ACT, 0, 0);
        chk(viol, 1'b1, "R3 double activate");
        step(C_NOP, 0, 0);
        chk(viol, 1'b0, "R12 flag one cycle");

        // R4 / R8: read window, early precharge rejected.
        step(C_RD, 0, 0);
        for (int k = 0; k < BL - 2; k++) step(C_NOP, 0, 0);
        chk(pre_ok[0], 1'b0, "R4 before read window");
        step(C_PRE, 0, 0);
        chk(viol, 1'b1, "R8 early precharge");
        chk(pre_ok[0], 1'b1, "R8 bank still open");

        // R6: single precharge and recovery.
        step(C_PRE, 0, 0);
        chk(act_ok[NB-1:1], 3'b111, "R6 others untouched");
        for (int k = 1; k < TRP; k++) begin
            chk(act_ok[0], 1'b0, "R6 recovering");
            step(C_NOP, 0, 0);
        end
        chk(act_ok[0], 1'b1, "R6 recovered");

        // R5: write to precharge delay.
        step(C_ACT, 1, 0);
        step(C_WR, 1, 0);
        for (int k = 1; k < BL + TDPL - 1; k++) begin
            chk(pre_ok[1], 1'b0, "R5 write hold");
            step(C_NOP, 0, 0);
        end
        chk(pre_ok[1], 1'b1, "R5 write window");

        // R9 / R13: commands to a closed bank.
        step(C_RD, 3, 0);
        chk(viol, 1'b1, "R9 read closed bank");
        chk(act_ok[3], 1'b1, "R9 no change");
        step(C_PRE, 3, 0);
        chk(viol, 1'b0, "R13 precharge closed");
        chk(act_ok[3], 1'b1, "R13 still closed");

        // R7: all-bank precharge ignoring bank_sel.
        step(C_ACT, 0, 0);
        step(C_ACT, 3, 0);
        step(C_PRE, 2, 1);
        chk(act_ok, 4'b0100, "R7 all-bank closing");
        chk(pre_ok, 4'b0000, "R7 none open");
        for (int k = 1; k < TRP; k++) step(C_NOP, 0, 0);
        chk(act_ok, 4'hF, "R7 all recovered");

        // R10: write with auto-close.
        step(C_ACT, 0, 0);
        step(C_WR, 0, 1);
        for (int k = 1; k < BL + TDPL + TRP - 1; k++) begin
            chk(act_ok[0] | pre_ok[0], 1'b0, "R10 auto-close busy");
            step(C_NOP, 0, 0);
        end
        chk(act_ok[0], 1'b1, "R10 auto-close done");

        // R11: auto-close interrupted by read to another bank.
        step(C_ACT, 0, 0);
        step(C_ACT, 1, 0);
        step(C_WR, 0, 1);
        step(C_RD, 1, 0);
        chk(viol, 1'b0, "R11 interrupt legal");
        for (int k = 1; k < TRP; k++) begin
            chk(act_ok[0], 1'b0, "R11 recovering");
            step(C_NOP, 0, 0);
        end
        chk(act_ok[0], 1'b1, "R11 early recovery");

        // R1: non-commands leave an open bank alone.
        step(C_ACT, 2, 0);
        step(C_REF, 2, 1);
        step(C_MRS, 2, 1);
        step(C_DES, 2, 1);
        chk(pre_ok[2], 1'b1, "R1 bank stays open");
        chk(viol, 1'b0, "R1 no violation");

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            logic [3:0] c;
            case (r)
                0, 1, 2: c = C_ACT;
                3:       c = C_RD;
                4:       c = C_WR;
                5:       c = C_PRE;
                6, 7:    c = C_NOP;
                8:       c = C_DES;
                default: c = C_REF;
            endcase
            step(c, $urandom_range(0, NB - 1), $urandom_range(0, 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule